// File: doc/BRIEF.md
# Area-Based External Bus Controller

This controller connects one internal master to an external memory bus. The top three bits of the 24-bit address choose one of eight equal 2-Mbyte areas. Each area has its own data width (8 or 16 bits), basic access length (2 or 3 states) and program wait count, which applies only to the 3-state length. Areas 0 to 3 each drive an active-low chip select. Areas 4 to 7 have no chip select.

The master holds a request until a one-cycle ready pulse returns. A 16-bit transfer to an 8-bit area runs as two byte cycles, and the master sees one completion. Area 0 can act as a burst ROM, where repeated reads within a small address window use a short access. Optional idle states separate a read from a following read to another area, and a read from a following write. Settings are loaded through a small register-write port.

Top module: `area_bus_ctrl`

## Requirements
- R1: After reset every area is 16 bits wide, 3-state, with 3 wait states; burst and both idle options are off. All chip selects and both strobes are inactive (high) and `rdy` is low.
- R2: The area is `addr[23:21]`. During an access to area i < 4, only `ext_cs_n[i]` is low. No chip select goes low for areas 4 to 7 or while idle.
- R3: A basic external cycle lasts 2 states when the area is set to 2-state, and 3 + W states when it is set to 3-state (W = 0..3). `rdy` is seen L cycles after the accepting edge, where L is the sum of all states, including any idle state.
- R4: A read on a 16-bit area returns all 16 bits of `ext_rdata`. A single-byte access (`req_wide`=0) to an 8-bit area uses lane [7:0] and returns `{8'h00, ext_rdata[7:0]}`. A byte write drives `req_wdata` unchanged.
- R5: A 16-bit access (`req_wide`=1) to an 8-bit area with even address A runs two byte cycles. The first is at A and carries the upper byte. The second is at A+1 and carries the lower byte. Both use lane [7:0], and the read result is `{byte@A, byte@A+1}`. One `rdy` follows the second cycle.
- R6: With burst on, a read cycle to area 0 takes 1 state (burst-length bit = 0) or 2 states (bit = 1). This applies only when the previous external cycle was a read to area 0 with the same `addr[23:4]`. Any other read to area 0 takes the full length.
- R7: With the area-change idle bit on, a read is preceded by one idle state when the previous external cycle was a read to a different area. No chip select or strobe is active during the idle state.
- R8: With the turnaround idle bit on, a write is preceded by one idle state when the previous external cycle was a read. No idle state is added when the previous cycle was a write.
- R9: Read and write strobes are never low together. In a cycle longer than one state, the strobe stays high in the first state, so each byte cycle of a split write gives its own strobe pulse.
- R10: `cfg_addr` 0..7 loads area settings: bit0 = 16-bit width, bit1 = 3-state, bits[3:2] = wait count. `cfg_addr` 8 loads globals: bit0 = burst on, bit1 = 2-state burst, bit2 = area-change idle, bit3 = turnaround idle. Writes to `cfg_addr` 9..15 change nothing.
- R11: `rdy` is a single-cycle pulse, given exactly once per accepted request. In that cycle the external bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 4 | Setting register select |
| cfg_wdata | input | 4 | Setting value |
| req | input | 1 | Access request, held until `rdy` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (a byte on [7:0]) |
| rdy | output | 1 | Completion pulse |
| rdata | output | 16 | Read result, valid with `rdy` |
| ext_addr | output | 24 | External address |
| ext_cs_n | output | 4 | Chip selects for areas 0 to 3 |
| ext_rd_n | output | 1 | Read strobe |
| ext_wr_n | output | 1 | Write strobe |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |

## Verification
The assertions assume the master follows the handshake. It raises `req` only while the controller is idle or in the `rdy` cycle, and it removes or replaces the request in that cycle. They also assume settings do not change while an access is in flight. The stimulus therefore issues each request at a falling edge and drops it one cycle later. It waits for `rdy` before the next request or setting write. Split transfers always use even addresses.

// File: rtl/area_bus_ctrl.sv
module area_bus_ctrl #(
  parameter int ADDR_W    = 24,
  parameter int NCS       = 4,
  parameter int BURST_LSB = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [3:0]        cfg_wdata,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rdy,
  output logic [15:0]       rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [NCS-1:0]    ext_cs_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic [15:0]       ext_wdata,
  input  logic [15:0]       ext_rdata
);
  localparam int AREAS    = 8;
  localparam int AREA_LSB = ADDR_W - 3;
  localparam int PAGE_W   = ADDR_W - BURST_LSB;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_ACC} st_t;

  logic [AREAS-1:0] a_wide, a_long;
  logic [1:0]       a_wait [AREAS];
  logic             g_burst, g_burst2, g_gap_area, g_gap_turn;

  st_t              st;
  logic [2:0]       cnt;
  logic             first, two_pend;
  logic [ADDR_W-1:0] op_addr, cyc_addr;
  logic             op_we, op_split, op_bus16;
  logic [15:0]      op_wdata, cyc_wdata;
  logic [7:0]       hi_byte;
  logic             h_valid, h_read;
  logic [2:0]       h_area;
  logic [PAGE_W-1:0] h_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_wide     <= '1;
      a_long     <= '1;
      for (int i = 0; i < AREAS; i++) a_wait[i] <= 2'd3;
      g_burst    <= 1'b0;
      g_burst2   <= 1'b0;
      g_gap_area <= 1'b0;
      g_gap_turn <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_addr[3]) begin
        a_wide[cfg_addr[2:0]] <= cfg_wdata[0];
        a_long[cfg_addr[2:0]] <= cfg_wdata[1];
        a_wait[cfg_addr[2:0]] <= cfg_wdata[3:2];
      end else if (cfg_addr[2:0] == 3'd0) begin
        g_burst    <= cfg_wdata[0];
        g_burst2   <= cfg_wdata[1];
        g_gap_area <= cfg_wdata[2];
        g_gap_turn <= cfg_wdata[3];
      end
    end
  end

  wire [2:0] q_area   = req_addr[ADDR_W-1:AREA_LSB];
  wire       q_split  = req_wide && !a_wide[q_area];
  wire       need_gap = h_valid && h_read &&
                        (req_we ? g_gap_turn : (g_gap_area && h_area != q_area));
  wire       accept   = (st == S_IDLE) && req;

  logic              start, s_we, s_pend;
  logic [ADDR_W-1:0] s_addr;
  logic [15:0]       s_data;

  always_comb begin
    start  = 1'b0;
    s_addr = req_addr;
    s_we   = req_we;
    s_pend = 1'b0;
    s_data = req_wdata;
    case (st)
      S_IDLE: begin
        start  = req && !need_gap;
        s_pend = q_split;
        s_data = q_split ? {8'h00, req_wdata[15:8]} : req_wdata;
      end
      S_GAP: begin
        start  = 1'b1;
        s_addr = op_addr;
        s_we   = op_we;
        s_pend = op_split;
        s_data = op_split ? {8'h00, op_wdata[15:8]} : op_wdata;
      end
      S_ACC: begin
        start  = (cnt == 3'd0) && two_pend;
        s_addr = {op_addr[ADDR_W-1:1], 1'b1};
        s_we   = op_we;
        s_data = {8'h00, op_wdata[7:0]};
      end
      default: ;
    endcase
  end

  wire [2:0] s_area = s_addr[ADDR_W-1:AREA_LSB];
  wire       s_hit  = g_burst && !s_we && (s_area == 3'd0) && h_valid && h_read &&
                      (h_area == 3'd0) && (h_page == s_addr[ADDR_W-1:BURST_LSB]);
  wire [2:0] s_len  = s_hit ? (g_burst2 ? 3'd2 : 3'd1) :
                      a_long[s_area] ? 3'd3 + {1'b0, a_wait[s_area]} : 3'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      first     <= 1'b0;
      two_pend  <= 1'b0;
      op_addr   <= '0;
      op_we     <= 1'b0;
      op_split  <= 1'b0;
      op_bus16  <= 1'b0;
      op_wdata  <= '0;
      cyc_addr  <= '0;
      cyc_wdata <= '0;
      hi_byte   <= '0;
      rdy       <= 1'b0;
      rdata     <= '0;
      h_valid   <= 1'b0;
      h_read    <= 1'b0;
      h_area    <= '0;
      h_page    <= '0;
    end else begin
      rdy <= 1'b0;
      if (accept) begin
        op_addr  <= req_addr;
        op_we    <= req_we;
        op_wdata <= req_wdata;
        op_split <= q_split;
        op_bus16 <= a_wide[q_area];
      end
      if (st == S_ACC && cnt == 3'd0 && two_pend) hi_byte <= ext_rdata[7:0];
      if (start) begin
        st        <= S_ACC;
        cnt       <= s_len - 3'd1;
        first     <= 1'b1;
        two_pend  <= s_pend;
        cyc_addr  <= s_addr;
        cyc_wdata <= s_data;
        h_valid   <= 1'b1;
        h_read    <= !s_we;
        h_area    <= s_area;
        h_page    <= s_addr[ADDR_W-1:BURST_LSB];
      end else if (accept) begin
        st <= S_GAP;
      end else if (st == S_ACC) begin
        first <= 1'b0;
        if (cnt != 3'd0) begin
          cnt <= cnt - 3'd1;
        end else begin
          st    <= S_IDLE;
          rdy   <= 1'b1;
          rdata <= op_split ? {hi_byte, ext_rdata[7:0]} :
                   op_bus16 ? ext_rdata : {8'h00, ext_rdata[7:0]};
        end
      end
    end
  end

  wire       in_acc   = (st == S_ACC);
  wire [2:0] cyc_area = cyc_addr[ADDR_W-1:AREA_LSB];
  wire       strobe   = in_acc && (!first || cnt == 3'd0);

  assign ext_addr  = cyc_addr;
  assign ext_wdata = cyc_wdata;
  assign ext_rd_n  = !(strobe && !op_we);
  assign ext_wr_n  = !(strobe && op_we);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign ext_cs_n[i] = !(in_acc && cyc_area == 3'(i));
  end
endmodule

// File: rtl/area_bus_ctrl_chk.sv
module area_bus_ctrl_chk #(
  parameter int ADDR_W = 24,
  parameter int NCS    = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              rdy,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [NCS-1:0]    ext_cs_n,
  input logic              ext_rd_n,
  input logic              ext_wr_n
);
  wire [2:0] area = ext_addr[ADDR_W-1:ADDR_W-3];

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  assert_cs_low_area_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs_n != '1) |-> (area < 3'(NCS)));

  assert_cs_with_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ext_rd_n || !ext_wr_n) && area < 3'(NCS)) |-> (ext_cs_n != '1));

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  assert_wr_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_wr_n) |-> $stable(ext_addr));

  assert_rdy_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  assert_rdy_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (ext_rd_n && ext_wr_n && (ext_cs_n == '1)));
endmodule

bind area_bus_ctrl area_bus_ctrl_chk #(.ADDR_W(ADDR_W), .NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .ext_addr(ext_addr),
  .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
);

// File: tb/area_bus_ctrl_tb.sv
`timescale 1ns/1ps
module area_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [3:0]  cfg_wdata = '0;
  logic        req = 1'b0, req_we = 1'b0, req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rdy;
  logic [15:0] rdata;
  logic [23:0] ext_addr;
  logic [3:0]  ext_cs_n;
  logic        ext_rd_n, ext_wr_n;
  logic [15:0] ext_wdata, ext_rdata;

  always #4 clk = ~clk;

  area_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req(req), .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rdy(rdy), .rdata(rdata), .ext_addr(ext_addr), .ext_cs_n(ext_cs_n),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  function automatic logic [15:0] mdl(input logic [23:0] a);
    return {~a[7:0], a[7:0] ^ 8'h5A};
  endfunction
  function automatic logic [7:0] lo(input logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign ext_rdata = mdl(ext_addr);

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  int          q_start[$], q_lat[$];
  logic [15:0] q_rd[$];
  bit          q_isrd[$];
  logic [3:0]  q_cs[$];
  string       q_tag[$];
  logic [3:0]  cs_acc = 4'hF;

  always @(negedge clk) begin
    if (rst_n) begin
      cs_acc = cs_acc & ext_cs_n;
      if (rdy) begin
        if (q_lat.size() == 0) begin
          check(1'b0, "R11", "ready without request", 1, 0);
        end else begin
          int st; int lt; logic [15:0] er; bit ir; logic [3:0] ec; string tg;
          st = q_start.pop_front(); lt = q_lat.pop_front(); er = q_rd.pop_front();
          ir = q_isrd.pop_front(); ec = q_cs.pop_front(); tg = q_tag.pop_front();
          check(cyc - st == lt, tg, "latency", cyc - st, lt);
          check(cs_acc == ec, tg, "chip selects", int'(cs_acc), int'(ec));
          if (ir) check(rdata == er, tg, "rdata", int'(rdata), int'(er));
        end
        cs_acc = 4'hF;
      end
    end
  end

  logic [23:0] w_a[$];
  logic [15:0] w_d[$];
  logic [23:0] cur_wa;
  logic [15:0] cur_wd;
  bit          wact = 1'b0;
  always @(negedge clk) begin
    if (!ext_wr_n) begin
      cur_wa = ext_addr; cur_wd = ext_wdata; wact = 1'b1;
    end else if (wact) begin
      w_a.push_back(cur_wa); w_d.push_back(cur_wd); wact = 1'b0;
    end
  end

  task automatic cfg(input logic [3:0] a, input logic [3:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic acc(input bit we, input bit wide, input logic [23:0] a, input logic [15:0] wd,
                     input int lat, input logic [15:0] er, input logic [3:0] ecs, input string tag);
    int guard = 0;
    q_start.push_back(cyc + 1); q_lat.push_back(lat); q_rd.push_back(er);
    q_isrd.push_back(!we); q_cs.push_back(ecs); q_tag.push_back(tag);
    req = 1'b1; req_we = we; req_wide = wide; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    while (!rdy && guard < 200) begin @(negedge clk); guard++; end
    if (guard >= 200) check(1'b0, tag, "no ready (timeout)", 0, 1);
  endtask

  task automatic wchk(input logic [23:0] a, input logic [15:0] d, input string tag);
    if (w_a.size() == 0) begin
      check(1'b0, tag, "missing write cycle", 0, int'(a));
    end else begin
      logic [23:0] ga; logic [15:0] gd;
      ga = w_a.pop_front(); gd = w_d.pop_front();
      check(ga == a, tag, "write address", int'(ga), int'(a));
      check(gd == d, tag, "write data", int'(gd), int'(d));
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ext_cs_n == 4'hF && ext_rd_n && ext_wr_n && !rdy, "R1", "idle outputs after reset",
          int'({ext_cs_n, ext_rd_n, ext_wr_n, rdy}), int'({4'hF, 1'b1, 1'b1, 1'b0}));
    // R1 R2 R4: reset settings give 3+3 states, full 16-bit read, area 1 select
    acc(0, 1, 24'h200010, 0, 6, mdl(24'h200010), 4'b1101, "R1");
    // R3 R10: area 2 set to 16-bit, 2-state
    cfg(4'd2, 4'b0001);
    acc(0, 1, 24'h400020, 0, 2, mdl(24'h400020), 4'b1011, "R3");
    // R4: area 3 8-bit, 3-state, 1 wait; byte read on low lane
    cfg(4'd3, 4'b0110);
    acc(0, 0, 24'h600031, 0, 4, {8'h00, lo(24'h600031)}, 4'b0111, "R4");
    // R5 split read and write, upper byte first
    acc(0, 1, 24'h600040, 0, 8, {lo(24'h600040), lo(24'h600041)}, 4'b0111, "R5");
    acc(1, 1, 24'h600050, 16'hBEEF, 8, 0, 4'b0111, "R5");
    @(negedge clk);
    wchk(24'h600050, 16'h00BE, "R5");
    wchk(24'h600051, 16'h00EF, "R9");
    // R4 byte write keeps data
    acc(1, 0, 24'h600061, 16'h00AB, 4, 0, 4'b0111, "R4");
    @(negedge clk);
    wchk(24'h600061, 16'h00AB, "R4");
    // R2: area 5 has no chip select
    acc(0, 1, 24'hA00000, 0, 6, mdl(24'hA00000), 4'hF, "R2");
    // R10: write to address 9 ignored, so no idle state on area change
    cfg(4'd9, 4'hF);
    acc(0, 1, 24'h400000, 0, 2, mdl(24'h400000), 4'b1011, "R10");
    // R7 R8: enable both idle options
    cfg(4'd8, 4'b1100);
    acc(0, 1, 24'h400004, 0, 2, mdl(24'h400004), 4'b1011, "R7");
    cfg(4'd1, 4'b0001);
    acc(0, 1, 24'h200000, 0, 3, mdl(24'h200000), 4'b1101, "R7");
    acc(1, 1, 24'h200002, 16'h1234, 3, 0, 4'b1101, "R8");
    @(negedge clk);
    wchk(24'h200002, 16'h1234, "R8");
    acc(1, 1, 24'h400006, 16'h5678, 2, 0, 4'b1011, "R8");
    @(negedge clk);
    wchk(24'h400006, 16'h5678, "R8");
    acc(0, 1, 24'h400008, 0, 2, mdl(24'h400008), 4'b1011, "R7");
    // R6: burst in area 0, 1-state then 2-state
    cfg(4'd8, 4'b0001);
    cfg(4'd0, 4'b0011);
    acc(0, 1, 24'h000100, 0, 3, mdl(24'h000100), 4'b1110, "R6");
    acc(0, 1, 24'h000102, 0, 1, mdl(24'h000102), 4'b1110, "R6");
    acc(0, 1, 24'h000104, 0, 1, mdl(24'h000104), 4'b1110, "R6");
    acc(0, 1, 24'h000110, 0, 3, mdl(24'h000110), 4'b1110, "R6");
    acc(0, 1, 24'h000112, 0, 1, mdl(24'h000112), 4'b1110, "R6");
    cfg(4'd8, 4'b0011);
    acc(0, 1, 24'h000114, 0, 2, mdl(24'h000114), 4'b1110, "R6");
    acc(1, 1, 24'h000116, 16'hCAFE, 3, 0, 4'b1110, "R6");
    acc(0, 1, 24'h000118, 0, 3, mdl(24'h000118), 4'b1110, "R6");
    cfg(4'd8, 4'b0000);
    acc(0, 1, 24'h00011A, 0, 3, mdl(24'h00011A), 4'b1110, "R6");
    // R3: 3-state with 2 waits
    cfg(4'd6, 4'b1011);
    acc(0, 1, 24'hC00000, 0, 5, mdl(24'hC00000), 4'hF, "R3");
    repeat (3) @(negedge clk);
    // R11: one ready per request
    check(q_lat.size() == 0, "R11", "pending completions", q_lat.size(), 0);
    summary();
    $finish;
  end
endmodule